// File: doc/BRIEF.md
# Two-Channel Segmented Current-Steering Input Decoder

This block is the digital front end of a dual 10-bit current-steering converter. Each of the two channels has its own clock and its own 10-bit code bus. On each rising edge of its clock a channel loads the code into an input register. The registered code is split into two parts. The five upper bits turn on a number of equal-weight unary cells, each worth 32 LSB, in thermometer order. The five lower bits drive five binary-weighted cells directly. Every cell has a switch enable for the true output leg and a complementary enable for the opposite leg. The enables are registered once more before they leave the block.

A behavioural integer model of the two leg currents, in LSB units, is registered next to the enables. It exists for checking and for system-level models. The true-leg value is counted from the true-side enables and the complementary value from the opposite-side enables. Analog sources, reference and full-scale adjustment sit outside this block.

Top module: `seg_dac_frontend`

## Requirements
- R1: Each channel loads its 10-bit code (bit 9 most significant) only on the rising edge of its own clock.
- R2: The two channels are fully independent: each one's outputs follow only its own clock and code, even when the clock periods are unrelated.
- R3: Unary true enable k (k = 0..30) is on exactly when the registered code bits [9:5], read as an unsigned number, exceed k, so the active cells always form a contiguous run starting at bit 0.
- R4: Binary true enable j (j = 0..4) equals registered code bit j. Stepping the code from 32m-1 to 32m turns all five binary enables off and turns on unary enable m-1.
- R5: Code 1023 gives true leg 1023 and complementary leg 0. Code 0 gives true leg 0 and complementary leg 1023. Midscale code 512 gives 512 and 511.
- R6: Every complementary enable is the exact bitwise inverse of its true enable, for both the unary and the binary cells.
- R7: The true-leg model equals 32 times the number of active unary cells plus the binary field. The two legs always sum to 1023.
- R8: A synchronous active-high reset, sampled on each channel's clock, clears the captured code. In the following cycle all true enables are off, all complementary enables are on, the true leg is 0 and the complementary leg is 1023.
- R9: A code present at rising edge N appears at the outputs after rising edge N+1 of the same clock: one register for capture and one for the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of channel A |
| clk_b | input | 1 | Clock of channel B |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| code_a | input | 10 | Channel A code, bit 9 MSB |
| code_b | input | 10 | Channel B code, bit 9 MSB |
| a_unary_on | output | 31 | Channel A unary enables, true leg |
| a_unary_off | output | 31 | Channel A unary enables, complementary leg |
| a_bin_on | output | 5 | Channel A binary enables, true leg |
| a_bin_off | output | 5 | Channel A binary enables, complementary leg |
| a_true_lsb | output | 10 | Channel A true-leg current model, LSB units |
| a_comp_lsb | output | 10 | Channel A complementary-leg current model, LSB units |
| b_unary_on | output | 31 | Channel B unary enables, true leg |
| b_unary_off | output | 31 | Channel B unary enables, complementary leg |
| b_bin_on | output | 5 | Channel B binary enables, true leg |
| b_bin_off | output | 5 | Channel B binary enables, complementary leg |
| b_true_lsb | output | 10 | Channel B true-leg current model, LSB units |
| b_comp_lsb | output | 10 | Channel B complementary-leg current model, LSB units |

## Verification
The following properties are checked on every clock of each channel:
- the thermometer runs contiguously from bit 0;
- the complementary enables are strict inverses of the true enables;
- the two leg models sum to 1023;
- the outputs are cleared after a reset cycle;
- the true-leg value equals the code presented two edges earlier.

Some behaviour only the bench scenarios can show:
- the exact cell pattern for each code, including the carry from the binary cells into a unary cell at each multiple of 32;
- the coding table end points and midscale;
- the independence of the two channels under unrelated clock periods, across a full sweep of all 1024 codes on each channel.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

    localparam int DATA_W     = 10;
    localparam int UPPER_W    = 5;
    localparam int LOWER_W    = DATA_W - UPPER_W;
    localparam int UNARY_N    = (1 << UPPER_W) - 1;
    localparam int UNARY_WT   = 1 << LOWER_W;
    localparam int FULL_CODE  = (1 << DATA_W) - 1;
    localparam int LSB_W      = DATA_W;
    localparam int NUM_CH     = 2;

    typedef logic [DATA_W-1:0]  code_t;
    typedef logic [UPPER_W-1:0] upper_t;
    typedef logic [LOWER_W-1:0] lower_t;
    typedef logic [UNARY_N-1:0] unary_t;
    typedef logic [LSB_W-1:0]   lsb_t;

    typedef struct packed {
        unary_t unary_on;
        unary_t unary_off;
        lower_t bin_on;
        lower_t bin_off;
    } switch_set_t;

    typedef struct packed {
        lsb_t true_leg;
        lsb_t comp_leg;
    } leg_model_t;

    localparam switch_set_t SW_IDLE = '{
        unary_on:  '0,
        unary_off: '1,
        bin_on:    '0,
        bin_off:   '1
    };

    localparam leg_model_t LEG_IDLE = '{
        true_leg: '0,
        comp_leg: lsb_t'(FULL_CODE)
    };

    // Weighted sum of a set of enables in LSB units
    function automatic lsb_t leg_weight(input unary_t unary, input lower_t bin);
        int acc;
        acc = 0;
        for (int k = 0; k < UNARY_N; k++) begin
            if (unary[k]) acc += UNARY_WT;
        end
        acc += int'(bin);
        return lsb_t'(acc);
    endfunction

endpackage

// File: rtl/seg_dac_in_reg.sv
module seg_dac_in_reg
    import seg_dac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_d,
    output code_t code_q
);

    always_ff @(posedge clk) begin
        if (rst) code_q <= '0;
        else     code_q <= code_d;
    end

endmodule

// File: rtl/seg_dac_segment_decode.sv
module seg_dac_segment_decode
    import seg_dac_pkg::*;
(
    input  code_t       code,
    output switch_set_t sw
);

    upper_t upper_field;
    lower_t lower_field;
    unary_t thermo;

    assign upper_field = code[DATA_W-1 -: UPPER_W];
    assign lower_field = code[LOWER_W-1:0];

    // One comparator per unary cell: cell k conducts when the field passes k
    for (genvar k = 0; k < UNARY_N; k++) begin : g_cell
        assign thermo[k] = (int'(upper_field) > k);
    end

    always_comb begin
        sw.unary_on  = thermo;
        sw.unary_off = ~thermo;
        sw.bin_on    = lower_field;
        sw.bin_off   = ~lower_field;
    end

endmodule

// File: rtl/seg_dac_leg_model.sv
module seg_dac_leg_model
    import seg_dac_pkg::*;
(
    input  switch_set_t sw,
    output leg_model_t  legs
);

    // Each leg is counted only from its own side's enables
    always_comb begin
        legs.true_leg = leg_weight(sw.unary_on,  sw.bin_on);
        legs.comp_leg = leg_weight(sw.unary_off, sw.bin_off);
    end

endmodule

// File: rtl/seg_dac_drive_reg.sv
module seg_dac_drive_reg
    import seg_dac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  switch_set_t sw_d,
    input  leg_model_t  legs_d,
    output switch_set_t sw_q,
    output leg_model_t  legs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q   <= SW_IDLE;
            legs_q <= LEG_IDLE;
        end else begin
            sw_q   <= sw_d;
            legs_q <= legs_d;
        end
    end

endmodule

// File: rtl/seg_dac_channel.sv
module seg_dac_channel
    import seg_dac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  code_t       code,
    output switch_set_t sw,
    output leg_model_t  legs
);

    code_t       code_q;
    switch_set_t sw_comb;
    leg_model_t  legs_comb;

    seg_dac_in_reg u_in_reg (
        .clk    (clk),
        .rst    (rst),
        .code_d (code),
        .code_q (code_q)
    );

    seg_dac_segment_decode u_decode (
        .code (code_q),
        .sw   (sw_comb)
    );

    seg_dac_leg_model u_model (
        .sw   (sw_comb),
        .legs (legs_comb)
    );

    seg_dac_drive_reg u_drive (
        .clk    (clk),
        .rst    (rst),
        .sw_d   (sw_comb),
        .legs_d (legs_comb),
        .sw_q   (sw),
        .legs_q (legs)
    );

endmodule

// File: rtl/seg_dac_frontend.sv
module seg_dac_frontend
    import seg_dac_pkg::*;
(
    input  logic               clk_a,
    input  logic               clk_b,
    input  logic               rst,
    input  logic [DATA_W-1:0]  code_a,
    input  logic [DATA_W-1:0]  code_b,
    output logic [UNARY_N-1:0] a_unary_on,
    output logic [UNARY_N-1:0] a_unary_off,
    output logic [LOWER_W-1:0] a_bin_on,
    output logic [LOWER_W-1:0] a_bin_off,
    output logic [LSB_W-1:0]   a_true_lsb,
    output logic [LSB_W-1:0]   a_comp_lsb,
    output logic [UNARY_N-1:0] b_unary_on,
    output logic [UNARY_N-1:0] b_unary_off,
    output logic [LOWER_W-1:0] b_bin_on,
    output logic [LOWER_W-1:0] b_bin_off,
    output logic [LSB_W-1:0]   b_true_lsb,
    output logic [LSB_W-1:0]   b_comp_lsb
);

    logic        ch_clk  [NUM_CH];
    code_t       ch_code [NUM_CH];
    switch_set_t ch_sw   [NUM_CH];
    leg_model_t  ch_legs [NUM_CH];

    assign ch_clk[0]  = clk_a;
    assign ch_clk[1]  = clk_b;
    assign ch_code[0] = code_a;
    assign ch_code[1] = code_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        seg_dac_channel u_channel (
            .clk  (ch_clk[c]),
            .rst  (rst),
            .code (ch_code[c]),
            .sw   (ch_sw[c]),
            .legs (ch_legs[c])
        );
    end

    assign a_unary_on  = ch_sw[0].unary_on;
    assign a_unary_off = ch_sw[0].unary_off;
    assign a_bin_on    = ch_sw[0].bin_on;
    assign a_bin_off   = ch_sw[0].bin_off;
    assign a_true_lsb  = ch_legs[0].true_leg;
    assign a_comp_lsb  = ch_legs[0].comp_leg;

    assign b_unary_on  = ch_sw[1].unary_on;
    assign b_unary_off = ch_sw[1].unary_off;
    assign b_bin_on    = ch_sw[1].bin_on;
    assign b_bin_off   = ch_sw[1].bin_off;
    assign b_true_lsb  = ch_legs[1].true_leg;
    assign b_comp_lsb  = ch_legs[1].comp_leg;

endmodule

// File: rtl/seg_dac_chan_chk.sv
module seg_dac_chan_chk
    import seg_dac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  code_in,
    input logic [UNARY_N-1:0] unary_on,
    input logic [UNARY_N-1:0] unary_off,
    input logic [LOWER_W-1:0] bin_on,
    input logic [LOWER_W-1:0] bin_off,
    input logic [LSB_W-1:0]   true_lsb,
    input logic [LSB_W-1:0]   comp_lsb
);

    // Edges seen since reset, saturating at two
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (rst)              seen <= '0;
        else if (seen != 2'd2) seen <= seen + 2'd1;
    end

    AST_THERMO_CONTIG: assert property (@(posedge clk) disable iff (rst)
        ((unary_on & (unary_on + 1'b1)) == '0)); // R3

    AST_LEGS_INVERSE: assert property (@(posedge clk) disable iff (rst)
        (unary_off == ~unary_on) && (bin_off == ~bin_on)); // R6

    AST_LEG_SUM: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, true_lsb} + {1'b0, comp_lsb}) == (LSB_W+1)'(FULL_CODE)); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (true_lsb == '0) && (unary_on == '0) && (bin_on == '0)); // R8

    AST_CAPTURE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2) |-> (true_lsb == $past(code_in, 2))); // R9

endmodule

bind seg_dac_frontend seg_dac_chan_chk u_chk_a (
    .clk       (clk_a),
    .rst       (rst),
    .code_in   (code_a),
    .unary_on  (a_unary_on),
    .unary_off (a_unary_off),
    .bin_on    (a_bin_on),
    .bin_off   (a_bin_off),
    .true_lsb  (a_true_lsb),
    .comp_lsb  (a_comp_lsb)
);

bind seg_dac_frontend seg_dac_chan_chk u_chk_b (
    .clk       (clk_b),
    .rst       (rst),
    .code_in   (code_b),
    .unary_on  (b_unary_on),
    .unary_off (b_unary_off),
    .bin_on    (b_bin_on),
    .bin_off   (b_bin_off),
    .true_lsb  (b_true_lsb),
    .comp_lsb  (b_comp_lsb)
);

// File: tb/test_seg_dac_frontend.sv
module test_seg_dac_frontend;

    localparam int CLK_PERIOD   = 10;
    localparam int CLK_B_PERIOD = 13;
    localparam int N_DIRECTED   = 10;
    localparam int N_STEPS      = N_DIRECTED + 1024;

    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst   = 1'b1;
    logic [9:0]  code_a = 10'h2AA;
    logic [9:0]  code_b = 10'h155;
    logic [30:0] a_unary_on, a_unary_off, b_unary_on, b_unary_off;
    logic [4:0]  a_bin_on, a_bin_off, b_bin_on, b_bin_off;
    logic [9:0]  a_true_lsb, a_comp_lsb, b_true_lsb, b_comp_lsb;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2.0)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2.0) clk_b = ~clk_b;

    seg_dac_frontend i_seg_dac_frontend (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
        .code_a(code_a), .code_b(code_b),
        .a_unary_on(a_unary_on), .a_unary_off(a_unary_off),
        .a_bin_on(a_bin_on), .a_bin_off(a_bin_off),
        .a_true_lsb(a_true_lsb), .a_comp_lsb(a_comp_lsb),
        .b_unary_on(b_unary_on), .b_unary_off(b_unary_off),
        .b_bin_on(b_bin_on), .b_bin_off(b_bin_off),
        .b_true_lsb(b_true_lsb), .b_comp_lsb(b_comp_lsb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int stim(input int ch, input int idx);
        int dir [N_DIRECTED] = '{0, 31, 32, 33, 63, 64, 512, 1023, 0, 992};
        if (idx < N_DIRECTED) return dir[idx];
        if (ch == 0) return idx - N_DIRECTED;
        return ((idx - N_DIRECTED) * 397 + 5) % 1024;
    endfunction

    // Compare one channel's ports against the model's code value
    task automatic compare(input int ch, input int exp_code, input bit in_rst);
        logic [30:0] uon, uoff, exp_u;
        logic [4:0]  bon, boff;
        int          tl, cl, upper, ones;
        string       tag;
        tag = (ch == 0) ? "chA" : "chB";
        if (ch == 0) begin
            uon = a_unary_on; uoff = a_unary_off; bon = a_bin_on; boff = a_bin_off;
            tl = int'(a_true_lsb); cl = int'(a_comp_lsb);
        end else begin
            uon = b_unary_on; uoff = b_unary_off; bon = b_bin_on; boff = b_bin_off;
            tl = int'(b_true_lsb); cl = int'(b_comp_lsb);
        end
        upper = exp_code / 32;
        exp_u = '0;
        for (int k = 0; k < 31; k++) if (upper > k) exp_u[k] = 1'b1;
        ones = $countones(uon);
        if (in_rst) begin
            check(tl == 0 && uon == '0 && bon == '0, "R8", {tag, " reset true side"}, tl, 0);
            check(cl == 1023 && uoff == '1 && boff == '1, "R8", {tag, " reset comp side"}, cl, 1023);
            return;
        end
        check(tl == exp_code, "R1 R2 R9", {tag, " true leg vs code"}, tl, exp_code);
        check(cl == 1023 - exp_code, "R7", {tag, " comp leg"}, cl, 1023 - exp_code);
        check(tl == 32 * ones + int'(bon), "R7", {tag, " leg weight"}, tl, 32 * ones + int'(bon));
        check(uon == exp_u, "R3", {tag, " unary pattern"}, uon, exp_u);
        check(uon == (31'h7FFFFFFF >> (31 - ones)), "R3", {tag, " thermometer contiguous"}, uon,
              (31'h7FFFFFFF >> (31 - ones)));
        check(bon == 5'(exp_code % 32), "R4", {tag, " binary cells"}, bon, exp_code % 32);
        check(uoff == ~uon && boff == ~bon, "R6", {tag, " complement"}, {uoff, boff}, {~uon, ~bon});
        if (exp_code > 0 && exp_code % 32 == 0)
            check(bon == '0 && uon[exp_code/32 - 1], "R4", {tag, " carry into unary"}, {uon, bon}, exp_u);
        if (exp_code == 1023)
            check(tl == 1023 && cl == 0, "R5", {tag, " all ones"}, {tl, cl}, {1023, 0});
        if (exp_code == 0)
            check(tl == 0 && cl == 1023, "R5", {tag, " all zeros"}, {tl, cl}, {0, 1023});
        if (exp_code == 512)
            check(tl == 512 && cl == 511, "R5", {tag, " midscale"}, {tl, cl}, {512, 511});
    endtask

    // Cycle model: capture register then enable register
    task automatic run_chan(input int ch);
        int  drv, mcode, mout, idx;
        bit  r_s;
        drv = (ch == 0) ? 'h2AA : 'h155;
        mcode = 0; mout = 0; idx = 0;
        while (idx < N_STEPS + 2) begin
            if (ch == 0) @(posedge clk_a); else @(posedge clk_b);
            r_s = rst;
            if (ch == 0) @(negedge clk_a); else @(negedge clk_b);
            if (r_s) begin
                mcode = 0; mout = 0;
                compare(ch, 0, 1'b1);
            end else begin
                mout  = mcode;
                mcode = drv;
                compare(ch, mout, 1'b0);
                drv = (idx < N_STEPS) ? stim(ch, idx) : 0;
                idx++;
                if (ch == 0) code_a = 10'(drv); else code_b = 10'(drv);
            end
        end
    endtask

    initial begin
        fork
            begin #(CLK_PERIOD * 10 + 2); rst = 1'b0; end
            run_chan(0);
            run_chan(1);
        join
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule